// File: doc/BRIEF.md
# Letterboxed Video Window Scaler

This block produces the raster timing for a progressive display of 640 visible pixels by 480 visible lines. It embeds a smaller game picture of 256 by 240 pixels inside that raster. Horizontal and vertical position counters run through the whole frame, blanking included, and the block decodes active-low sync pulses, a display-enable and a start-of-frame strobe from them. Every size, porch, pulse width and window origin is a parameter, so the blanking lengths can be tuned to what a given monitor accepts.

While the scan is inside the game window, the block asks an upstream pixel source for the picture coordinate it needs. It sends that request early enough that a source with one cycle of read latency can answer in time. The returned colour is 15 bits wide with 5 bits per primary. The block widens each primary to 8 bits and drives the resulting 24-bit colour out in step with the matching counters. Every active position outside the window is black, and so is all blanking.

The output stage is fully registered. The counters, syncs, enable, strobe and colour seen at the outputs in any one cycle all describe the same pixel.

Top module: `lbox_scaler_top`

## Requirements
- R1: While `rst` is high, and until the first output pixel arrives, the outputs are inactive: `disp_en`=0, `sof`=0, `req_vld`=0, `rgb_out`=0 and `hs_n`=`vs_n`=1.
- R2: `disp_x` counts 0 to H_TOT-1 and then wraps to 0. `disp_y` advances by one on each wrap of `disp_x` and wraps to 0 after V_TOT-1. H_TOT is H_ACT+H_FP+H_SW+H_BP, and V_TOT is formed the same way. The output position (0,0) appears in the third cycle after reset is released.
- R3: `disp_en` is 1 exactly when `disp_x` < H_ACT and `disp_y` < V_ACT.
- R4: `hs_n` is 0 exactly when H_ACT+H_FP <= `disp_x` < H_ACT+H_FP+H_SW. `vs_n` is 0 exactly when V_ACT+V_FP <= `disp_y` < V_ACT+V_FP+V_SW.
- R5: `sof` is 1 for exactly one cycle per frame, in the cycle where `disp_x`=0 and `disp_y`=0.
- R6: `req_vld` is 1 exactly two cycles before the outputs show a position inside the window X0 <= x < X0+WIN_W, Y0 <= y < Y0+WIN_H. In that cycle `req_x` = x-X0 and `req_y` = y-Y0.
- R7: Inside the window, `rgb_out` is the widened form of the `px_in` value that the source presents in the cycle after the request. `px_in[14:10]` is red, `[9:5]` is green and `[4:0]` is blue. `rgb_out[23:16]` is red, `[15:8]` is green and `[7:0]` is blue.
- R8: Each 5-bit primary c is widened to the 8-bit value {c, c[4:2]}, so 0 maps to 0x00 and 31 maps to 0xFF.
- R9: At an active position outside the window, `rgb_out` is 0 whatever `px_in` carries.
- R10: Whenever `disp_en` is 0, `rgb_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| px_in | input | 15 | Game pixel from the source, 5:5:5 colour, valid the cycle after a request |
| req_vld | output | 1 | A game pixel request is being issued |
| req_x | output | $clog2(WIN_W) | Requested game column |
| req_y | output | $clog2(WIN_H) | Requested game line |
| disp_x | output | $clog2(H_TOT) | Horizontal position of the current output pixel |
| disp_y | output | $clog2(V_TOT) | Vertical position of the current output pixel |
| hs_n | output | 1 | Horizontal sync, active low |
| vs_n | output | 1 | Vertical sync, active low |
| disp_en | output | 1 | Active display region |
| sof | output | 1 | One-cycle start-of-frame strobe at position (0,0) |
| rgb_out | output | 24 | Display colour, 8 bits per primary |

## Verification
The position counters feed a three-register pipeline. Position (0,0) therefore reaches the outputs three edges after reset is released, and the bench checks it at that exact point. Each later check samples on the falling edge and advances the bench's own expected position by one per cycle. A request precedes the output showing its position by two cycles, so the bench keeps a two-deep history of the request ports. The bench models the pixel source as a register that answers one cycle after a request. Each colour is then checked in the cycle where the position it belongs to is on the outputs. The source returns all-ones when nothing is requested, so a request that comes one cycle too early or too late shows up as a wrong colour.

// File: rtl/lbox_pkg.sv
package lbox_pkg;
  // Colour widths shared by the colour stage and the top.
  localparam int SRC_CH_W = 5;
  localparam int DST_CH_W = 8;
  localparam int N_CH     = 3;
  localparam int SRC_PIX_W = SRC_CH_W * N_CH;
  localparam int DST_PIX_W = DST_CH_W * N_CH;
endpackage

// File: rtl/lbox_raster_cnt.sv
module lbox_raster_cnt #(
  parameter int H_TOT = 800,
  parameter int V_TOT = 525,
  parameter int HW    = $clog2(H_TOT),
  parameter int VW    = $clog2(V_TOT)
) (
  input  logic          clk,
  input  logic          rst,
  output logic [HW-1:0] h_pos,
  output logic [VW-1:0] v_pos
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);
  localparam logic [VW-1:0] V_LAST = VW'(V_TOT - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      h_pos <= '0;
      v_pos <= '0;
    end else if (h_pos == H_LAST) begin
      h_pos <= '0;
      v_pos <= (v_pos == V_LAST) ? '0 : v_pos + 1'b1;
    end else begin
      h_pos <= h_pos + 1'b1;
    end
  end
endmodule

// File: rtl/lbox_region_decode.sv
module lbox_region_decode #(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SW  = 96,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SW  = 2,
  parameter int WIN_W = 256,
  parameter int WIN_H = 240,
  parameter int X0    = 192,
  parameter int Y0    = 120,
  parameter int HW    = 10,
  parameter int VW    = 10,
  parameter int GXW   = $clog2(WIN_W),
  parameter int GYW   = $clog2(WIN_H)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [HW-1:0]  h_in,
  input  logic [VW-1:0]  v_in,
  output logic [HW-1:0]  h_q,
  output logic [VW-1:0]  v_q,
  output logic           de_q,
  output logic           hs_n_q,
  output logic           vs_n_q,
  output logic           sof_q,
  output logic           win_q,
  output logic           req_vld,
  output logic [GXW-1:0] req_x,
  output logic [GYW-1:0] req_y
);
  localparam logic [HW-1:0] HA_L   = HW'(H_ACT);
  localparam logic [VW-1:0] VA_L   = VW'(V_ACT);
  localparam logic [HW-1:0] HS_BEG = HW'(H_ACT + H_FP);
  localparam logic [HW-1:0] HS_END = HW'(H_ACT + H_FP + H_SW);
  localparam logic [VW-1:0] VS_BEG = VW'(V_ACT + V_FP);
  localparam logic [VW-1:0] VS_END = VW'(V_ACT + V_FP + V_SW);
  localparam logic [HW-1:0] WX_BEG = HW'(X0);
  localparam logic [HW-1:0] WX_END = HW'(X0 + WIN_W);
  localparam logic [VW-1:0] WY_BEG = VW'(Y0);
  localparam logic [VW-1:0] WY_END = VW'(Y0 + WIN_H);

  logic act_c, hs_c, vs_c, win_c, sof_c;

  always_comb begin
    act_c = (h_in < HA_L) && (v_in < VA_L);
    hs_c  = (h_in >= HS_BEG) && (h_in < HS_END);
    vs_c  = (v_in >= VS_BEG) && (v_in < VS_END);
    win_c = (h_in >= WX_BEG) && (h_in < WX_END) &&
            (v_in >= WY_BEG) && (v_in < WY_END);
    sof_c = (h_in == '0) && (v_in == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_q     <= '0;
      v_q     <= '0;
      de_q    <= 1'b0;
      hs_n_q  <= 1'b1;
      vs_n_q  <= 1'b1;
      sof_q   <= 1'b0;
      win_q   <= 1'b0;
      req_vld <= 1'b0;
      req_x   <= '0;
      req_y   <= '0;
    end else begin
      h_q     <= h_in;
      v_q     <= v_in;
      de_q    <= act_c;
      hs_n_q  <= ~hs_c;
      vs_n_q  <= ~vs_c;
      sof_q   <= sof_c;
      win_q   <= win_c;
      req_vld <= win_c;
      req_x   <= win_c ? GXW'(h_in - WX_BEG) : '0;
      req_y   <= win_c ? GYW'(v_in - WY_BEG) : '0;
    end
  end
endmodule

// File: rtl/lbox_color_stage.sv
module lbox_color_stage #(
  parameter int SRC_CH_W = lbox_pkg::SRC_CH_W,
  parameter int DST_CH_W = lbox_pkg::DST_CH_W,
  parameter int N_CH     = lbox_pkg::N_CH
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       show,
  input  logic [SRC_CH_W*N_CH-1:0]   px,
  output logic [DST_CH_W*N_CH-1:0]   rgb_q
);
  localparam int REP_W = DST_CH_W - SRC_CH_W;

  for (genvar k = 0; k < N_CH; k++) begin : g_ch
    logic [SRC_CH_W-1:0] c;
    assign c = px[k*SRC_CH_W +: SRC_CH_W];
    always_ff @(posedge clk) begin
      if (rst)       rgb_q[k*DST_CH_W +: DST_CH_W] <= '0;
      else if (show) rgb_q[k*DST_CH_W +: DST_CH_W] <= {c, c[SRC_CH_W-1 -: REP_W]};
      else           rgb_q[k*DST_CH_W +: DST_CH_W] <= '0;
    end
  end
endmodule

// File: rtl/lbox_scaler_top.sv
module lbox_scaler_top #(
  parameter int H_ACT = 640,
  parameter int H_FP  = 16,
  parameter int H_SW  = 96,
  parameter int H_BP  = 48,
  parameter int V_ACT = 480,
  parameter int V_FP  = 10,
  parameter int V_SW  = 2,
  parameter int V_BP  = 33,
  parameter int WIN_W = 256,
  parameter int WIN_H = 240,
  parameter int X0    = (H_ACT - WIN_W) / 2,
  parameter int Y0    = (V_ACT - WIN_H) / 2,
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP,
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP,
  localparam int HW    = $clog2(H_TOT),
  localparam int VW    = $clog2(V_TOT),
  localparam int GXW   = $clog2(WIN_W),
  localparam int GYW   = $clog2(WIN_H),
  localparam int PW    = lbox_pkg::SRC_PIX_W,
  localparam int OW    = lbox_pkg::DST_PIX_W
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [PW-1:0]  px_in,
  output logic           req_vld,
  output logic [GXW-1:0] req_x,
  output logic [GYW-1:0] req_y,
  output logic [HW-1:0]  disp_x,
  output logic [VW-1:0]  disp_y,
  output logic           hs_n,
  output logic           vs_n,
  output logic           disp_en,
  output logic           sof,
  output logic [OW-1:0]  rgb_out
);
  logic [HW-1:0] cnt_h;
  logic [VW-1:0] cnt_v;

  lbox_raster_cnt #(.H_TOT(H_TOT), .V_TOT(V_TOT), .HW(HW), .VW(VW)) u_cnt (
    .clk(clk), .rst(rst), .h_pos(cnt_h), .v_pos(cnt_v)
  );

  // Stage 1: decoded position, request issued here.
  logic [HW-1:0] s1_h;
  logic [VW-1:0] s1_v;
  logic          s1_de, s1_hs_n, s1_vs_n, s1_sof, s1_win;

  lbox_region_decode #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW),
    .WIN_W(WIN_W), .WIN_H(WIN_H), .X0(X0), .Y0(Y0),
    .HW(HW), .VW(VW), .GXW(GXW), .GYW(GYW)
  ) u_dec (
    .clk(clk), .rst(rst), .h_in(cnt_h), .v_in(cnt_v),
    .h_q(s1_h), .v_q(s1_v), .de_q(s1_de), .hs_n_q(s1_hs_n),
    .vs_n_q(s1_vs_n), .sof_q(s1_sof), .win_q(s1_win),
    .req_vld(req_vld), .req_x(req_x), .req_y(req_y)
  );

  // Stage 2: waits while the source fetches the pixel.
  logic [HW-1:0] s2_h;
  logic [VW-1:0] s2_v;
  logic          s2_de, s2_hs_n, s2_vs_n, s2_sof, s2_win;

  always_ff @(posedge clk) begin
    if (rst) begin
      s2_h <= '0; s2_v <= '0; s2_de <= 1'b0;
      s2_hs_n <= 1'b1; s2_vs_n <= 1'b1; s2_sof <= 1'b0; s2_win <= 1'b0;
    end else begin
      s2_h <= s1_h; s2_v <= s1_v; s2_de <= s1_de;
      s2_hs_n <= s1_hs_n; s2_vs_n <= s1_vs_n; s2_sof <= s1_sof; s2_win <= s1_win;
    end
  end

  // Stage 3: output registers.
  always_ff @(posedge clk) begin
    if (rst) begin
      disp_x <= '0; disp_y <= '0; disp_en <= 1'b0;
      hs_n <= 1'b1; vs_n <= 1'b1; sof <= 1'b0;
    end else begin
      disp_x <= s2_h; disp_y <= s2_v; disp_en <= s2_de;
      hs_n <= s2_hs_n; vs_n <= s2_vs_n; sof <= s2_sof;
    end
  end

  lbox_color_stage u_col (
    .clk(clk), .rst(rst), .show(s2_win), .px(px_in), .rgb_q(rgb_out)
  );
endmodule

// File: rtl/lbox_scaler_chk.sv
module lbox_scaler_chk #(
  parameter int HW    = 10,
  parameter int VW    = 10,
  parameter int H_TOT = 800,
  parameter int OW    = 24
) (
  input logic          clk,
  input logic          rst,
  input logic [HW-1:0] disp_x,
  input logic [VW-1:0] disp_y,
  input logic          disp_en,
  input logic          hs_n,
  input logic          sof,
  input logic          req_vld,
  input logic [OW-1:0] rgb_out
);
  localparam logic [HW-1:0] H_LAST = HW'(H_TOT - 1);

  p_hwrap_r2: assert property (@(posedge clk) disable iff (rst)
    (disp_x == H_LAST) |=> (disp_x == '0));

  p_hsync_blank_r4: assert property (@(posedge clk) disable iff (rst)
    !hs_n |-> !disp_en);

  p_sof_origin_r5: assert property (@(posedge clk) disable iff (rst)
    sof |-> (disp_x == '0) && (disp_y == '0) && disp_en);

  p_req_ahead_r6: assert property (@(posedge clk) disable iff (rst)
    $past(req_vld, 2) |-> disp_en);

  p_blank_black_r10: assert property (@(posedge clk) disable iff (rst)
    !disp_en |-> (rgb_out == '0));
endmodule

bind lbox_scaler_top lbox_scaler_chk #(
  .HW(HW), .VW(VW), .H_TOT(H_TOT), .OW(OW)
) u_chk (
  .clk(clk), .rst(rst), .disp_x(disp_x), .disp_y(disp_y),
  .disp_en(disp_en), .hs_n(hs_n), .sof(sof),
  .req_vld(req_vld), .rgb_out(rgb_out)
);

// File: tb/lbox_scaler_tb_top.sv
module lbox_scaler_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H_ACT = 24, H_FP = 2, H_SW = 3, H_BP = 3;
  localparam int V_ACT = 16, V_FP = 1, V_SW = 2, V_BP = 2;
  localparam int WIN_W = 8, WIN_H = 6, X0 = 8, Y0 = 5;
  localparam int H_TOT = H_ACT + H_FP + H_SW + H_BP;
  localparam int V_TOT = V_ACT + V_FP + V_SW + V_BP;
  localparam int HW = $clog2(H_TOT), VW = $clog2(V_TOT);
  localparam int GXW = $clog2(WIN_W), GYW = $clog2(WIN_H);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [14:0] px_in = 15'h7FFF;
  logic req_vld, hs_n, vs_n, disp_en, sof;
  logic [GXW-1:0] req_x;
  logic [GYW-1:0] req_y;
  logic [HW-1:0] disp_x;
  logic [VW-1:0] disp_y;
  logic [23:0] rgb_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  int ex = 0, ey = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lbox_scaler_top #(
    .H_ACT(H_ACT), .H_FP(H_FP), .H_SW(H_SW), .H_BP(H_BP),
    .V_ACT(V_ACT), .V_FP(V_FP), .V_SW(V_SW), .V_BP(V_BP),
    .WIN_W(WIN_W), .WIN_H(WIN_H), .X0(X0), .Y0(Y0)
  ) dut_i (
    .clk(clk), .rst(rst), .px_in(px_in), .req_vld(req_vld),
    .req_x(req_x), .req_y(req_y), .disp_x(disp_x), .disp_y(disp_y),
    .hs_n(hs_n), .vs_n(vs_n), .disp_en(disp_en), .sof(sof), .rgb_out(rgb_out)
  );

  // Game picture content: red = column, green = 6*line, blue = 31 - 4*column.
  function automatic logic [14:0] src_pix(input int x, input int y);
    logic [4:0] r, g, b;
    r = 5'(x);
    g = 5'(y * 6);
    b = 5'(31 - 4 * x);
    return {r, g, b};
  endfunction

  function automatic logic [7:0] widen(input logic [4:0] c);
    return {c, c[4:2]};
  endfunction

  function automatic logic [23:0] expect_rgb(input logic [14:0] p);
    return {widen(p[14:10]), widen(p[9:5]), widen(p[4:0])};
  endfunction

  function automatic bit in_win(input int x, input int y);
    return (x >= X0) && (x < X0 + WIN_W) && (y >= Y0) && (y < Y0 + WIN_H);
  endfunction

  // Upstream source with one cycle of read latency; all-ones when idle.
  always @(posedge clk)
    px_in <= req_vld ? src_pix(int'(req_x), int'(req_y)) : 15'h7FFF;

  task automatic check(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (ex == H_TOT - 1) begin
      ex = 0;
      ey = (ey == V_TOT - 1) ? 0 : ey + 1;
    end else begin
      ex++;
    end
  endtask

  task automatic t_reset();
    rst = 1'b1;
    repeat (4) @(negedge clk);
    check(disp_en == 1'b0, "R1", "disp_en in reset", 32'(disp_en), 0);
    check(sof == 1'b0, "R1", "sof in reset", 32'(sof), 0);
    check(req_vld == 1'b0, "R1", "req_vld in reset", 32'(req_vld), 0);
    check(rgb_out == 24'h0, "R1", "rgb in reset", 32'(rgb_out), 0);
    check(hs_n && vs_n, "R1", "syncs in reset", {30'h0, hs_n, vs_n}, 3);
  endtask

  task automatic t_startup();
    rst = 1'b0;
    @(negedge clk);
    check(disp_en == 1'b0 && sof == 1'b0, "R1", "fill cycle 1", {30'h0, disp_en, sof}, 0);
    @(negedge clk);
    check(disp_en == 1'b0 && sof == 1'b0, "R1", "fill cycle 2", {30'h0, disp_en, sof}, 0);
    @(negedge clk);
    ex = 0; ey = 0;
    check(sof == 1'b1, "R5", "sof at first pixel", 32'(sof), 1);
    check(disp_x == '0 && disp_y == '0, "R2", "first position",
          {16'(disp_y), 16'(disp_x)}, 0);
  endtask

  task automatic t_raster();
    int bad = 0;
    for (int n = 0; n < H_TOT * V_TOT + 3; n++) begin
      step();
      if (int'(disp_x) != ex || int'(disp_y) != ey) begin
        if (bad == 0)
          check(1'b0, "R2", "position", {16'(disp_y), 16'(disp_x)}, {16'(ey), 16'(ex)});
        bad++;
      end
    end
    check(bad == 0, "R2", "position mismatches over frame", 32'(bad), 0);
  endtask

  task automatic t_sync();
    int bad_de = 0, bad_hs = 0, bad_vs = 0, bad_sof = 0, sof_seen = 0;
    for (int n = 0; n < H_TOT * V_TOT; n++) begin
      bit e_de, e_hs, e_vs, e_sof;
      step();
      e_de  = (ex < H_ACT) && (ey < V_ACT);
      e_hs  = !((ex >= H_ACT + H_FP) && (ex < H_ACT + H_FP + H_SW));
      e_vs  = !((ey >= V_ACT + V_FP) && (ey < V_ACT + V_FP + V_SW));
      e_sof = (ex == 0) && (ey == 0);
      if (disp_en != e_de) bad_de++;
      if (hs_n != e_hs) bad_hs++;
      if (vs_n != e_vs) bad_vs++;
      if (sof != e_sof) bad_sof++;
      if (sof) sof_seen++;
    end
    check(bad_de == 0, "R3", "disp_en mismatches", 32'(bad_de), 0);
    check(bad_hs == 0, "R4", "hs_n mismatches", 32'(bad_hs), 0);
    check(bad_vs == 0, "R4", "vs_n mismatches", 32'(bad_vs), 0);
    check(bad_sof == 0, "R5", "sof mismatches", 32'(bad_sof), 0);
    check(sof_seen == 1, "R5", "sof pulses per frame", 32'(sof_seen), 1);
  endtask

  task automatic t_window();
    bit v1 = 0, v2 = 0;
    int x1 = 0, x2 = 0, y1 = 0, y2 = 0;
    int bad_req = 0, bad_in = 0, bad_out = 0, bad_blank = 0, n_in = 0;
    bit saw_ff = 0, saw_00 = 0;
    for (int n = 0; n < H_TOT * V_TOT; n++) begin
      bit w;
      logic [23:0] e_rgb;
      step();
      w = in_win(ex, ey) && (ex < H_ACT) && (ey < V_ACT);
      if (n >= 2) begin
        if (v2 != w) bad_req++;
        else if (w && (x2 != ex - X0 || y2 != ey - Y0)) bad_req++;
      end
      if (w) begin
        n_in++;
        e_rgb = expect_rgb(src_pix(ex - X0, ey - Y0));
        if (rgb_out != e_rgb) begin
          if (bad_in == 0) check(1'b0, "R7", "window colour", 32'(rgb_out), 32'(e_rgb));
          bad_in++;
        end
        if (rgb_out[7:0] == 8'hFF) saw_ff = 1;
        if (rgb_out[15:8] == 8'h00) saw_00 = 1;
      end else if (disp_en) begin
        if (rgb_out != 24'h0) bad_out++;
      end else begin
        if (rgb_out != 24'h0) bad_blank++;
      end
      v2 = v1; x2 = x1; y2 = y1;
      v1 = req_vld; x1 = int'(req_x); y1 = int'(req_y);
    end
    check(bad_req == 0, "R6", "request timing/coordinate mismatches", 32'(bad_req), 0);
    check(n_in == WIN_W * WIN_H, "R6", "window pixels per frame", 32'(n_in), 32'(WIN_W * WIN_H));
    check(bad_in == 0, "R7", "window colour mismatches", 32'(bad_in), 0);
    check(saw_ff, "R8", "blue 31 widened to FF seen", 32'(saw_ff), 1);
    check(saw_00, "R8", "green 0 widened to 00 seen", 32'(saw_00), 1);
    check(bad_out == 0, "R9", "non-black outside window", 32'(bad_out), 0);
    check(bad_blank == 0, "R10", "non-black in blanking", 32'(bad_blank), 0);
  endtask

  task automatic t_corners();
    // Window corners at fixed output positions.
    while (!(ex == X0 && ey == Y0)) step();
    check(rgb_out == expect_rgb(src_pix(0, 0)), "R7", "top-left corner",
          32'(rgb_out), 32'(expect_rgb(src_pix(0, 0))));
    while (!(ex == X0 + WIN_W && ey == Y0)) step();
    check(rgb_out == 24'h0 && disp_en, "R9", "first column right of window",
          32'(rgb_out), 0);
    while (!(ex == X0 + WIN_W - 1 && ey == Y0 + WIN_H - 1)) step();
    check(rgb_out == expect_rgb(src_pix(WIN_W - 1, WIN_H - 1)), "R8", "bottom-right corner",
          32'(rgb_out), 32'(expect_rgb(src_pix(WIN_W - 1, WIN_H - 1))));
    while (!(ex == X0 - 1 && ey == Y0 + WIN_H)) step();
    check(rgb_out == 24'h0, "R9", "line below window", 32'(rgb_out), 0);
  endtask

  initial begin
    t_reset();
    t_startup();
    t_raster();
    t_sync();
    t_window();
    t_corners();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule